// File: doc/BRIEF.md
# Processor Reset and Strap Sequencer

This block turns a platform reset into the reset seen by the processor. While the asynchronous, active-low platform reset is low, the processor reset output is held low. When the platform reset goes high, the block keeps the processor in reset for a further programmable stretch of host clocks, chosen to be about one millisecond. The stretch length is a parameter, so a bench can use a short value.

The block also drives a bus-request strap line low for the whole time the processor is in reset. The processor samples this line on the rising edge of its reset. The strap is therefore set up well before that edge. After the edge it is held low for a bounded number of host clocks, and then its output enable drops so the pad goes to high impedance.

An assertion of the platform reset forces the processor reset low and turns the strap driver on at once, without waiting for a clock. It also restarts the whole sequence from the start.

Top module: `cpu_reset_sequencer`

## Requirements
- R1: Whenever `plat_rst_n` is low, `cpu_rst_n` is low. A new assertion takes effect without waiting for any clock edge.
- R2: After `plat_rst_n` rises between two clock edges, `cpu_rst_n` rises right after the (STRETCH_CYCLES+2)-th following rising clock edge. Two of those edges are taken by the input synchronizer.
- R3: Whenever `cpu_rst_n` is low, `strap_oe` is 1. `strap_o` is always 0, so the strap line is pulled low whenever it is driven.
- R4: `strap_oe` is 1 for at least 4 clock cycles before every rising edge of `cpu_rst_n`. The STRETCH_CYCLES parameter must be at least 4.
- R5: After `cpu_rst_n` rises, `strap_oe` stays 1 for exactly HOLD_CYCLES clock cycles and then goes to 0. HOLD_CYCLES must lie between 2 and 20.
- R6: Once the strap is released, `strap_oe` stays 0 and `cpu_rst_n` stays 1 for as long as `plat_rst_n` stays high.
- R7: If `plat_rst_n` is asserted again at any point (during the stretch, during the hold or after release), `cpu_rst_n` goes to 0 and `strap_oe` goes to 1 at once. The next release then takes the full R2 delay and the full R5 hold again.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Host clock |
| plat_rst_n | input | 1 | Platform reset, asynchronous, active low |
| cpu_rst_n | output | 1 | Processor reset, active low |
| strap_o | output | 1 | Value put on the bus-request strap when driven (always 0) |
| strap_oe | output | 1 | Output enable of the strap driver; 0 means high impedance |

## Verification
The clocked assertions are switched off while `plat_rst_n` is low. They assume that any platform reset pulse covers at least one rising clock edge, so that the checker's own cycle counters are cleared. They also assume that each release is followed by enough clean cycles for the history they look back on to exist. The stimulus changes `plat_rst_n` only just after falling clock edges. It holds every reset pulse for at least one full cycle, and it picks its random reassertion points from the stretch phase, the hold phase and the released phase. The immediate-effect property is checked apart from the clocked ones, in the same cycle the reset is driven.

// File: rtl/cpu_rst_seq_pkg.sv
// Package: shared constants and state type for the processor reset sequencer.
// Assumes: nothing beyond IEEE 1800-2017.
package cpu_rst_seq_pkg;

    // Number of flops in the platform reset synchronizer.
    localparam int unsigned SYNC_STAGES = 2;

    // Minimum strap setup before processor reset release, in host clocks.
    localparam int unsigned STRAP_SETUP_MIN = 4;

    // Legal window for the strap hold after processor reset release.
    localparam int unsigned STRAP_HOLD_MIN = 2;
    localparam int unsigned STRAP_HOLD_MAX = 20;

    // Sequencer phases.
    typedef enum logic [1:0] {
        PH_STRETCH = 2'd0,   // processor in reset, strap driven low
        PH_HOLD    = 2'd1,   // processor running, strap still driven low
        PH_DONE    = 2'd2    // processor running, strap released
    } seq_phase_e;

endpackage

// File: rtl/plat_rst_sync.sv
// Module: plat_rst_sync
// Purpose: brings the asynchronous platform reset into the host clock domain.
// Assumes: the clear is taken at once (asynchronously) and the release is seen
// after STAGES rising edges. This chain is the only logic in the block with an
// asynchronous clear. It is what makes a reset pulse shorter than a clock
// period still restart the sequence.
module plat_rst_sync #(
    parameter int unsigned STAGES = 2
) (
    input  logic clk,
    input  logic async_rst_n,
    output logic sync_rst_n
);

    logic [STAGES-1:0] chain_q;

    // Shift ones in after release; clear the whole chain on assertion.
    always_ff @(posedge clk or negedge async_rst_n) begin
        if (!async_rst_n) begin
            chain_q <= '0;
        end else begin
            chain_q <= {chain_q[STAGES-2:0], 1'b1};
        end
    end

    assign sync_rst_n = chain_q[STAGES-1];

endmodule

// File: rtl/seq_phase_timer.sv
// Module: seq_phase_timer
// Purpose: counts the host clocks of one sequencer phase against a limit.
// Assumes: limit >= 1. The clear input wins over the count enable. The
// terminal flag is raised in the last cycle of a counted phase.
module seq_phase_timer #(
    parameter int unsigned WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear,
    input  logic             count_en,
    input  logic [WIDTH-1:0] limit,
    output logic             last
);

    logic [WIDTH-1:0] count_q;

    // Phase cycle counter with synchronous active-low reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count_q <= '0;
        end else if (clear) begin
            count_q <= '0;
        end else if (count_en) begin
            count_q <= count_q + 1'b1;
        end
    end

    // Terminal flag: this enabled cycle is the last one of the phase.
    always_comb begin
        last = count_en && (count_q == limit - 1'b1);
    end

endmodule

// File: rtl/seq_phase_fsm.sv
// Module: seq_phase_fsm
// Purpose: steps through stretch, hold and done, and gives the registered
// "released" and "strap drive" flags.
// Assumes: rst_n is the synchronized platform reset. The phase timer
// restarts on every phase change, using the last flag as its clear.
module seq_phase_fsm
    import cpu_rst_seq_pkg::*;
#(
    parameter int unsigned STRETCH_CYCLES = 16,
    parameter int unsigned HOLD_CYCLES    = 8,
    parameter int unsigned WIDTH          = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             phase_last,
    output logic             timer_en,
    output logic [WIDTH-1:0] timer_limit,
    output logic             released,
    output logic             strap_drive
);

    localparam logic [WIDTH-1:0] STRETCH_LIM = WIDTH'(STRETCH_CYCLES);
    localparam logic [WIDTH-1:0] HOLD_LIM    = WIDTH'(HOLD_CYCLES);

    seq_phase_e phase_q;
    seq_phase_e phase_d;

    // Next-phase logic: move on when the timer reports the last cycle.
    always_comb begin
        phase_d = phase_q;
        unique case (phase_q)
            PH_STRETCH: if (phase_last) phase_d = PH_HOLD;
            PH_HOLD:    if (phase_last) phase_d = PH_DONE;
            PH_DONE:    phase_d = PH_DONE;
            default:    phase_d = PH_STRETCH;
        endcase
    end

    // Phase register with synchronous active-low reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase_q <= PH_STRETCH;
        end else begin
            phase_q <= phase_d;
        end
    end

    // Timer control: count in the two timed phases, pick their limit.
    always_comb begin
        timer_en    = (phase_q == PH_STRETCH) || (phase_q == PH_HOLD);
        timer_limit = (phase_q == PH_HOLD) ? HOLD_LIM : STRETCH_LIM;
    end

    // Output flags decoded from the registered phase.
    always_comb begin
        released    = (phase_q != PH_STRETCH);
        strap_drive = (phase_q != PH_DONE);
    end

endmodule

// File: rtl/cpu_reset_sequencer.sv
// Module: cpu_reset_sequencer (top)
// Purpose: makes the processor reset from the platform reset, stretched by
// STRETCH_CYCLES host clocks. Drives the bus-request strap low through the
// reset release and for HOLD_CYCLES clocks after it, then releases it.
// Assumes: plat_rst_n may change at any time. Its assertion is combined
// into the outputs directly, so it needs no clock edge to act. The strap
// value is a constant low; only its enable is sequenced.
module cpu_reset_sequencer
    import cpu_rst_seq_pkg::*;
#(
    parameter int unsigned STRETCH_CYCLES = 100000,
    parameter int unsigned HOLD_CYCLES    = 8
) (
    input  logic clk,
    input  logic plat_rst_n,
    output logic cpu_rst_n,
    output logic strap_o,
    output logic strap_oe
);

    localparam int unsigned MAX_LIMIT = (STRETCH_CYCLES > HOLD_CYCLES) ?
                                        STRETCH_CYCLES : HOLD_CYCLES;
    localparam int unsigned TW        = $clog2(MAX_LIMIT + 1);

    // Elaboration-time parameter checks.
    if (HOLD_CYCLES < STRAP_HOLD_MIN || HOLD_CYCLES > STRAP_HOLD_MAX) begin : g_bad_hold
        $error("HOLD_CYCLES must lie in the strap hold window");
    end
    if (STRETCH_CYCLES < STRAP_SETUP_MIN) begin : g_bad_stretch
        $error("STRETCH_CYCLES must cover the strap setup time");
    end

    logic          sync_rst_n;
    logic          phase_last;
    logic          timer_en;
    logic [TW-1:0] timer_limit;
    logic          released;
    logic          strap_drive;

    plat_rst_sync #(
        .STAGES (SYNC_STAGES)
    ) u_sync (
        .clk         (clk),
        .async_rst_n (plat_rst_n),
        .sync_rst_n  (sync_rst_n)
    );

    seq_phase_timer #(
        .WIDTH (TW)
    ) u_timer (
        .clk      (clk),
        .rst_n    (sync_rst_n),
        .clear    (phase_last),
        .count_en (timer_en),
        .limit    (timer_limit),
        .last     (phase_last)
    );

    seq_phase_fsm #(
        .STRETCH_CYCLES (STRETCH_CYCLES),
        .HOLD_CYCLES    (HOLD_CYCLES),
        .WIDTH          (TW)
    ) u_fsm (
        .clk         (clk),
        .rst_n       (sync_rst_n),
        .phase_last  (phase_last),
        .timer_en    (timer_en),
        .timer_limit (timer_limit),
        .released    (released),
        .strap_drive (strap_drive)
    );

    // Output gating: a raw platform reset overrides the sequenced flags.
    always_comb begin
        cpu_rst_n = plat_rst_n & released;
        strap_oe  = ~plat_rst_n | strap_drive;
        strap_o   = 1'b0;
    end

endmodule

// File: rtl/cpu_reset_sequencer_checker.sv
// Module: cpu_reset_sequencer_checker
// Purpose: properties of the reset and strap sequence, bound to the top.
// Assumes: every platform reset pulse covers at least one rising clock edge.
module cpu_reset_sequencer_checker #(
    parameter int unsigned STRETCH_CYCLES = 16,
    parameter int unsigned HOLD_CYCLES    = 8
) (
    input logic clk,
    input logic plat_rst_n,
    input logic cpu_rst_n,
    input logic strap_o,
    input logic strap_oe
);

    localparam int unsigned DW = $clog2(STRETCH_CYCLES + 4);

    logic [DW-1:0] pre_cnt_q;
    logic [4:0]    hold_cnt_q;

    // Counts sampled cycles with the platform out of reset and the processor held.
    always_ff @(posedge clk or negedge plat_rst_n) begin
        if (!plat_rst_n) begin
            pre_cnt_q <= '0;
        end else if (!cpu_rst_n) begin
            pre_cnt_q <= pre_cnt_q + 1'b1;
        end
    end

    // Counts sampled cycles with the processor running and the strap driven.
    always_ff @(posedge clk) begin
        if (!cpu_rst_n) begin
            hold_cnt_q <= '0;
        end else if (strap_oe && hold_cnt_q != 5'd31) begin
            hold_cnt_q <= hold_cnt_q + 1'b1;
        end
    end

    // R1: a low platform reset always shows on the processor reset.
    always @(negedge clk) begin
        if (!plat_rst_n) begin
            p_follow_plat_r1: assert (!cpu_rst_n);
        end
    end

    // R2: release comes exactly STRETCH_CYCLES+2 cycles after the platform release.
    p_release_delay_r2: assert property (@(posedge clk) disable iff (!plat_rst_n)
        $rose(cpu_rst_n) |-> (pre_cnt_q == DW'(STRETCH_CYCLES + 2)));

    // R3: the strap is driven low whenever the processor is in reset.
    p_strap_in_reset_r3: assert property (@(posedge clk) disable iff (!plat_rst_n)
        !cpu_rst_n |-> (strap_oe && !strap_o));

    // R4: the strap was already driven four cycles before the release edge.
    p_strap_setup_r4: assert property (@(posedge clk) disable iff (!plat_rst_n)
        $rose(cpu_rst_n) |-> ($past(strap_oe, 4) && $past(strap_oe, 1)));

    // R5: the strap enable drops after exactly HOLD_CYCLES running cycles.
    p_strap_hold_r5: assert property (@(posedge clk) disable iff (!plat_rst_n)
        $fell(strap_oe) |-> (hold_cnt_q == 5'(HOLD_CYCLES)));

    // R6: once released, the strap stays released.
    p_strap_stays_off_r6: assert property (@(posedge clk) disable iff (!plat_rst_n)
        !strap_oe |=> !strap_oe);

    // R6: once running, the processor stays out of reset.
    p_cpu_stays_up_r6: assert property (@(posedge clk) disable iff (!plat_rst_n)
        cpu_rst_n |=> cpu_rst_n);

endmodule

bind cpu_reset_sequencer cpu_reset_sequencer_checker #(
    .STRETCH_CYCLES (STRETCH_CYCLES),
    .HOLD_CYCLES    (HOLD_CYCLES)
) u_checker (
    .clk        (clk),
    .plat_rst_n (plat_rst_n),
    .cpu_rst_n  (cpu_rst_n),
    .strap_o    (strap_o),
    .strap_oe   (strap_oe)
);

// File: tb/cpu_reset_sequencer_test.sv
// Bench: directed and seeded random platform reset pulses, with checks at the
// ports against delays worked out from the parameters.
module cpu_reset_sequencer_test;

    localparam int CLK_PERIOD = 10;
    localparam int STRETCH    = 10;
    localparam int HOLD       = 5;

    logic clk = 1'b0;
    logic plat_rst_n = 1'b0;
    logic cpu_rst_n;
    logic strap_o;
    logic strap_oe;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    cpu_reset_sequencer #(
        .STRETCH_CYCLES (STRETCH),
        .HOLD_CYCLES    (HOLD)
    ) uut (
        .clk        (clk),
        .plat_rst_n (plat_rst_n),
        .cpu_rst_n  (cpu_rst_n),
        .strap_o    (strap_o),
        .strap_oe   (strap_oe)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // Expected number of clock edges from platform release to processor release.
    function automatic int exp_release_delay(int stretch);
        return stretch + 2;
    endfunction

    // Expected number of cycles the strap stays driven after processor release.
    function automatic int exp_hold(int hold);
        return hold;
    endfunction

    task automatic check(bit ok, string req, int actual, int expected);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, actual, expected);
        end
    endtask

    // Assert the platform reset just after a falling edge and check the outputs at once.
    task automatic assert_plat(int hold_cycles);
        plat_rst_n = 1'b0;
        #1;
        check(cpu_rst_n == 1'b0, "R1", cpu_rst_n, 0);
        check(strap_oe == 1'b1 && strap_o == 1'b0, "R3", {strap_oe, strap_o}, 2);
        repeat (hold_cycles) @(negedge clk);
    endtask

    // Release the platform reset and follow the sequence. If cut_at >= 0,
    // reassert at that many edges after release (R7).
    task automatic release_and_follow(int cut_at);
        int n;
        int rise_at;
        int setup;
        int held;
        rise_at = -1;
        setup   = 0;
        held    = 0;
        plat_rst_n = 1'b1;
        for (n = 1; n <= exp_release_delay(STRETCH) + HOLD + 6; n++) begin
            @(negedge clk);
            if (n == cut_at) begin
                assert_plat(1);
                check(cpu_rst_n == 1'b0 && strap_oe == 1'b1, "R7",
                      {cpu_rst_n, strap_oe}, 1);
                return;
            end
            if (rise_at < 0) begin
                if (cpu_rst_n) begin
                    rise_at = n;
                    check(n == exp_release_delay(STRETCH), "R2", n, exp_release_delay(STRETCH));
                    check(setup >= 4, "R4", setup, 4);
                end else begin
                    if (strap_oe && !strap_o) setup++;
                    else check(1'b0, "R3", {strap_oe, strap_o}, 2);
                end
            end
            if (rise_at >= 0 && strap_oe) held++;
            if (rise_at >= 0 && n > rise_at && !cpu_rst_n)
                check(1'b0, "R6", cpu_rst_n, 1);
        end
        check(rise_at == exp_release_delay(STRETCH), "R2", rise_at, exp_release_delay(STRETCH));
        check(held == exp_hold(HOLD), "R5", held, exp_hold(HOLD));
        check(strap_oe == 1'b0 && cpu_rst_n == 1'b1, "R6", {cpu_rst_n, strap_oe}, 2);
    endtask

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        #(CLK_PERIOD * 150000);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual 0 expected 1");
            $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        int seed;
        int cut;
        seed = $urandom(32'h5EED_0042);
        // Reset state (R1, R3).
        @(negedge clk);
        #1;
        check(cpu_rst_n == 1'b0, "R1", cpu_rst_n, 0);
        check(strap_oe == 1'b1 && strap_o == 1'b0, "R3", {strap_oe, strap_o}, 2);
        repeat (3) @(negedge clk);

        // Directed full sequence (R2, R4, R5, R6).
        release_and_follow(-1);
        repeat (20) @(negedge clk);
        check(cpu_rst_n == 1'b1 && strap_oe == 1'b0, "R6", {cpu_rst_n, strap_oe}, 2);

        // Directed reassertion after release, during stretch, during hold (R7).
        assert_plat(2);
        release_and_follow(3);
        repeat (2) @(negedge clk);
        release_and_follow(exp_release_delay(STRETCH) + 2);
        repeat (2) @(negedge clk);
        release_and_follow(exp_release_delay(STRETCH) - 1);
        // The next release must take the full delay and hold again (R7).
        release_and_follow(-1);

        // Seeded random pulses and cut points.
        for (int i = 0; i < 40; i++) begin
            assert_plat(1 + int'($urandom_range(5)));
            cut = int'($urandom_range(exp_release_delay(STRETCH) + HOLD + 4));
            if ($urandom_range(3) == 0) cut = -1;
            if (cut == 0) cut = -1;
            release_and_follow(cut);
            if (cut < 0) repeat (int'($urandom_range(4))) @(negedge clk);
        end
        plat_rst_n = 1'b0;
        @(negedge clk);
        plat_rst_n = 1'b1;
        release_and_follow(-1);

        done = 1'b1;
        $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule